// File: doc/BRIEF.md
# Two-Lane Serial ADC Readout Controller

This block is the host side of a serial link to an eight-channel, 16-bit data converter. The converter shifts out its results on two serial data lanes. When a readout is started, the controller pulls chip select low. It then produces a serial clock that it derives from the system clock. The converter changes its output bits on rising edges of that clock, and the controller captures them on falling edges. Each completed 16-bit word is filed into one of eight channel result registers.

Two settings are taken when a readout starts. The first is the lane mode. In single-lane mode, all eight words arrive on lane A. In dual-lane mode, each lane carries four words: lane A supplies channels 1 to 4 and lane B supplies channels 5 to 8, so the readout takes half the time. The second is the chip-select style. Chip select can stay low across all words, or it can be raised for a short gap between consecutive words.

The converter drives a first-data flag. This flag must be high while the first word of the frame is being shifted. The controller samples the flag with every bit of that word and raises a sticky alignment error if it ever reads low. When the last word has been stored, the controller emits a one-cycle done pulse and chip select returns high.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, cs_n and sclk are high, done and align_err are low, and every channel register reads zero.
- R2: sclk runs at the system clock divided by the even parameter DIV, with a 50% duty cycle, and it idles high. The first falling edge comes DIV/2 cycles after cs_n falls.
- R3: Each bit is captured at the system clock edge that drives sclk low. A word is 16 such captures, MSB first. A frame contains exactly 16 falling sclk edges per word read from a lane.
- R4: With dual_lane=0, eight words are taken from lane A and stored as channels 1 to 8 in order. Channel n sits at ch_data[16n-1:16(n-1)]. Lane B has no effect in this mode.
- R5: With dual_lane=1, four words are read per lane. The lane A words go to channels 1 to 4 and the lane B words go to channels 5 to 8. Mode inputs are sampled when a start is accepted.
- R6: With cs_gap=0, cs_n stays low from the start until the frame ends. With cs_gap=1, cs_n goes high for DIV/2 cycles between words, and sclk is high during that gap. sclk is high whenever cs_n is high.
- R7: done is a one-cycle pulse, and cs_n rises on the same edge. done is seen DIV*16*words + (cs_gap ? DIV/2*(words-1) : 0) cycles after the edge that accepted start.
- R8: align_err is set if first_flag is low at any capture of the frame's first word. It is cleared when the next start is accepted. The flag is ignored on later words.
- R9: A start request that arrives while a readout is in progress is ignored. The frame timing and data are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Readout request, accepted only when idle |
| dual_lane | input | 1 | 1: read both lanes, 0: lane A only |
| cs_gap | input | 1 | 1: raise chip select between words |
| lane_a | input | 1 | Serial data lane A |
| lane_b | input | 1 | Serial data lane B |
| first_flag | input | 1 | Converter first-data indicator |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| ch_data | output | NCH*WORD_W | Channel results, channel 1 in the low 16 bits |
| done | output | 1 | One-cycle frame-complete pulse |
| align_err | output | 1 | Sticky first-data alignment error |

## Verification
The bench builds the controller with DIV=4, so each half period of sclk is two system cycles. At that setting every rising and falling edge and every chip-select gap can be counted exactly, while a full single-lane frame still takes only about five hundred cycles. The bench models the converter and sweeps every combination of lane mode and chip-select style over several data frames. These frames include all-ones/all-zeros words, a misaligned flag on the first and on the last bit of the first word, a flag left high after the first word, and a stray start request in the middle of a frame. The converter model, the expected channel values and the expected latencies are all computed arithmetically in the bench.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} rd_state_e;

  // index of the final word of a frame
  function automatic int last_word(input logic dual, input int nch);
    return dual ? (nch / 2 - 1) : (nch - 1);
  endfunction

  // destination channel (zero based) of a word from a lane
  function automatic int dest_chan(input logic on_b, input int idx, input int nch);
    return on_b ? (idx + nch / 2) : idx;
  endfunction

endpackage

// File: rtl/adc_half_tick.sv
module adc_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              din_a,
  input  logic              din_b,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b
);
  logic [WORD_W-2:0] sh_a, sh_b;

  assign word_a = {sh_a, din_a};
  assign word_b = {sh_b, din_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a <= '0;
      sh_b <= '0;
    end else if (shift) begin
      sh_a <= word_a[WORD_W-2:0];
      sh_b <= word_b[WORD_W-2:0];
    end
  end
endmodule

// File: rtl/adc_chan_bank.sv
module adc_chan_bank #(
  parameter int NCH    = 8,
  parameter int WORD_W = 16,
  parameter int WCW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_a,
  input  logic                  wr_b,
  input  logic [WCW-1:0]        idx,
  input  logic [WORD_W-1:0]     data_a,
  input  logic [WORD_W-1:0]     data_b,
  output logic [NCH*WORD_W-1:0] ch_data
);
  int dst_a, dst_b;

  always_comb begin
    dst_a = adc_rd_pkg::dest_chan(1'b0, int'(idx), NCH);
    dst_b = adc_rd_pkg::dest_chan(1'b1, int'(idx), NCH);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                   ch_data[c*WORD_W +: WORD_W] <= '0;
      else if (wr_a && dst_a == c)  ch_data[c*WORD_W +: WORD_W] <= data_a;
      else if (wr_b && dst_b == c)  ch_data[c*WORD_W +: WORD_W] <= data_b;
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int WORD_W = 16,
  parameter int NCH    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  dual_lane,
  input  logic                  cs_gap,
  input  logic                  lane_a,
  input  logic                  lane_b,
  input  logic                  first_flag,
  output logic                  cs_n,
  output logic                  sclk,
  output logic [NCH*WORD_W-1:0] ch_data,
  output logic                  done,
  output logic                  align_err
);
  localparam int HALF = DIV / 2;
  localparam int BCW  = $clog2(WORD_W);
  localparam int WCW  = (NCH > 2) ? $clog2(NCH) : 1;

  rd_state_e      state;
  logic [BCW-1:0] bit_cnt;
  logic [WCW-1:0] word_cnt;
  logic           fin_q, dual_q, gap_q;
  logic           tick;

  // named events for the checker
  logic busy, fall_evt, rise_evt, word_end, last_w, frame_end, first_word;
  logic [WORD_W-1:0] word_a, word_b;

  assign busy       = (state != ST_IDLE);
  assign fall_evt   = (state == ST_RUN) && tick && sclk;
  assign rise_evt   = (state == ST_RUN) && tick && !sclk;
  assign word_end   = fall_evt && (bit_cnt == BCW'(WORD_W - 1));
  assign last_w     = (word_cnt == WCW'(last_word(dual_q, NCH)));
  assign frame_end  = rise_evt && fin_q && last_w;
  assign first_word = (word_cnt == '0);

  adc_half_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  adc_lane_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift(fall_evt),
    .din_a(lane_a), .din_b(lane_b), .word_a(word_a), .word_b(word_b)
  );

  adc_chan_bank #(.NCH(NCH), .WORD_W(WORD_W), .WCW(WCW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_a(word_end), .wr_b(word_end && dual_q),
    .idx(word_cnt), .data_a(word_a), .data_b(word_b), .ch_data(ch_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      bit_cnt   <= '0;
      word_cnt  <= '0;
      fin_q     <= 1'b0;
      dual_q    <= 1'b0;
      gap_q     <= 1'b0;
      done      <= 1'b0;
      align_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RUN;
          cs_n      <= 1'b0;
          sclk      <= 1'b1;
          bit_cnt   <= '0;
          word_cnt  <= '0;
          fin_q     <= 1'b0;
          align_err <= 1'b0;
          dual_q    <= dual_lane;
          gap_q     <= cs_gap;
        end
        ST_RUN: if (tick) begin
          if (sclk) begin
            sclk    <= 1'b0;
            fin_q   <= (bit_cnt == BCW'(WORD_W - 1));
            bit_cnt <= (bit_cnt == BCW'(WORD_W - 1)) ? '0 : bit_cnt + 1'b1;
            if (first_word && !first_flag) align_err <= 1'b1;
          end else begin
            sclk  <= 1'b1;
            fin_q <= 1'b0;
            if (fin_q) begin
              if (last_w) begin
                state <= ST_IDLE;
                cs_n  <= 1'b1;
                done  <= 1'b1;
              end else begin
                word_cnt <= word_cnt + 1'b1;
                if (gap_q) begin
                  state <= ST_GAP;
                  cs_n  <= 1'b1;
                end
              end
            end
          end
        end
        ST_GAP: if (tick) begin
          state <= ST_RUN;
          cs_n  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int WCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           first_flag,
  input logic           cs_n,
  input logic           sclk,
  input logic           done,
  input logic           align_err,
  input logic           fall_evt,
  input logic           frame_end,
  input logic           busy,
  input logic           first_word,
  input logic [WCW-1:0] word_cnt
);
  // R6
  sclk_idle_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R3
  sample_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> !cs_n);

  // R2
  sclk_fall_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  // R7
  end_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done);

  // R8
  align_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && first_word && !first_flag) |=> align_err);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_end && word_cnt != '0) |=> (word_cnt != '0));
endmodule

bind adc_readout_ctrl adc_readout_chk #(.WCW(WCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .first_flag(first_flag),
  .cs_n(cs_n), .sclk(sclk), .done(done), .align_err(align_err),
  .fall_evt(fall_evt), .frame_end(frame_end), .busy(busy),
  .first_word(first_word), .word_cnt(word_cnt)
);

// File: tb/sim_adc_readout_ctrl.sv
`timescale 1ns/1ps
module sim_adc_readout_ctrl;
  localparam int DIV = 4;
  localparam int W   = 16;
  localparam int NCH = 8;
  localparam int H   = DIV / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, dual_lane, cs_gap, lane_a, lane_b, first_flag;
  logic cs_n, sclk, done, align_err;
  logic [NCH*W-1:0] ch_data;

  int checks = 0;
  int errors = 0;

  adc_readout_ctrl #(.DIV(DIV), .WORD_W(W), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_lane(dual_lane),
    .cs_gap(cs_gap), .lane_a(lane_a), .lane_b(lane_b), .first_flag(first_flag),
    .cs_n(cs_n), .sclk(sclk), .ch_data(ch_data), .done(done), .align_err(align_err)
  );

  function automatic logic [W-1:0] val(input int f, input int c);
    if (f % 5 == 0) return c[0] ? '1 : '0;
    return W'(f * 40503 + c * 9973 + 16'h3C5A);
  endfunction

  function automatic logic bit_at(input int f, input int c, input int b);
    logic [W-1:0] v;
    v = val(f, c);
    return v[W-1-b];
  endfunction

  // converter model: bit index k advances on each rising sclk edge
  int k = 0, frm = 0, bad = -1;
  logic late = 1'b0, dual_m = 1'b0;
  always @(posedge sclk) k <= k + 1;
  assign lane_a     = bit_at(frm, (k / W) % NCH, k % W);
  assign lane_b     = dual_m ? bit_at(frm, (k / W + NCH / 2) % NCH, k % W) : ~lane_a;
  assign first_flag = (k < W) ? (k != bad) : late;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit dm, input bit gm, input int f, input int b,
                           input bit lt, input bit extra);
    int n, falls, first_low, second_low, cs_hi, words, expd, gaps;
    bit prev;
    words = dm ? NCH / 2 : NCH;
    gaps  = gm ? H * (words - 1) : 0;
    expd  = DIV * W * words + gaps + 1;
    @(negedge clk);
    dual_lane = dm; cs_gap = gm; dual_m = dm;
    frm = f; bad = b; late = lt; k = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1; falls = 0; first_low = 0; second_low = 0; cs_hi = 0; prev = 1'b1;
    chk(cs_n == 1'b0, "R6", "cs_n after start", int'(cs_n), 0);
    chk(sclk == 1'b1, "R2", "sclk after start", int'(sclk), 1);
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (extra && n == 20) start = 1'b1;
      if (extra && n == 21) start = 1'b0;
      if (prev && !sclk) begin
        falls++;
        if (falls == 1) first_low = n;
        if (falls == 2) second_low = n;
      end
      prev = sclk;
      if (cs_n && !done) cs_hi++;
    end
    chk(n == expd, "R7", "done latency", n, expd);
    chk(cs_n == 1'b1, "R7", "cs_n at done", int'(cs_n), 1);
    chk(first_low == H + 1, "R2", "first fall", first_low, H + 1);
    chk(second_low - first_low == DIV, "R2", "sclk period", second_low - first_low, DIV);
    chk(falls == W * words, "R3", "fall count", falls, W * words);
    chk(cs_hi == gaps, "R6", "cs gap cycles", cs_hi, gaps);
    for (int c = 0; c < NCH; c++) begin
      if (dm) chk(ch_data[c*W +: W] == val(f, c), "R5", $sformatf("dual ch%0d", c + 1),
                  int'(ch_data[c*W +: W]), int'(val(f, c)));
      else    chk(ch_data[c*W +: W] == val(f, c), "R4", $sformatf("single ch%0d", c + 1),
                  int'(ch_data[c*W +: W]), int'(val(f, c)));
    end
    chk(align_err == (b >= 0 && b < W), "R8", "align_err", int'(align_err),
        int'(b >= 0 && b < W));
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", int'(done), 0);
    if (extra) begin
      for (int i = 0; i < 2 * DIV; i++) begin
        @(negedge clk);
        chk(cs_n == 1'b1 && done == 1'b0, "R9", "no restart", int'(cs_n), 1);
      end
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dual_lane = 1'b0; cs_gap = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle lines", int'({cs_n, sclk}), 3);
    chk(done == 1'b0 && align_err == 1'b0, "R1", "idle flags", int'({done, align_err}), 0);
    chk(ch_data == '0, "R1", "channels zero", int'(ch_data[W-1:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int dm = 0; dm < 2; dm++) begin
      for (int gm = 0; gm < 2; gm++) begin
        for (int f = 0; f < 5; f++) begin
          int b;
          b = (f == 1) ? 0 : (f == 2) ? W - 1 : (f == 3) ? W : -1;
          run_frame(dm[0], gm[0], dm * 20 + gm * 10 + f, b, f == 4, f == 3);
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule